// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the operating state of a serial transfer engine and turns host register writes into that state. The host writes a 2-bit request code through a one-cycle write strobe. The block has three states: reset, run and pause. It also reports a settle flag that is high once a change has finished. While the flag is low, the block refuses new requests and records each refused write in a sticky status bit.

The datapath receives three control outputs. A one-cycle clear strobe fires each time the block enters reset. A shift enable is high while the block is in run and settled. A hold level is high while the block is in pause.

To leave pause for reset, the host must write the clear code twice, with no other write between the two. A separate soft-reset write forces the block back to reset from any state at any time.

Top module: `engine_run_ctrl`

## Requirements
- R1: After the asynchronous reset, the state is reset (code 0), the settle flag is 1, the sticky bit is 0, and the clear strobe, shift enable and hold are all 0.
- R2: The request codes are 0 for reset, 1 for run, 3 for pause and 2 for clear. While in reset or run with the flag high, a write of 0, 1 or 3 moves the state to that code.
- R3: Any accepted write that targets a state drives the settle flag low on the next edge. The flag stays low for exactly SETTLE_CYCLES cycles and then returns high.
- R4: A state write that arrives while the flag is low leaves the state unchanged and sets the sticky bit. The sticky bit stays set until a reset or a soft reset.
- R5: In pause, a first clear write (code 2) leaves the state in pause with the flag still high. A second clear write as the very next write, even in the very next cycle, moves the state to reset.
- R6: In pause, after a first clear write, any non-clear write leaves the state in pause. A later clear write must then be written twice again.
- R7: In pause without a pending clear, a write of 1 goes to run, a write of 3 stays in pause (with a settle period), and a write of 0 has no effect.
- R8: While in reset or run, a clear write (code 2) has no effect.
- R9: A soft-reset write with bit 0 set has these effects: it forces the state to reset, starts a settle period, clears the sticky bit and drops any pending clear. It is accepted even while the flag is low, and it wins over a state write in the same cycle. A soft-reset write with bit 0 clear has no effect.
- R10: The clear strobe is high for exactly one cycle after each entry into reset. Shift enable equals (state is run) AND flag. Hold equals (state is pause). At most one of the three is high at any time.
- R11: The readback word carries the state in bits 1:0 and the settle flag in bit 2. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_i | input | 1 | State request write strobe |
| st_code_i | input | 2 | Requested code: 0 reset, 1 run, 2 clear, 3 pause |
| srst_wr_i | input | 1 | Soft-reset register write strobe |
| srst_bit_i | input | 1 | Soft-reset write data bit 0 |
| st_rdata_o | output | DW | Readback: {zeros, flag, state} |
| ign_sticky_o | output | 1 | Sticky bit set by refused state writes |
| clr_o | output | 1 | One-cycle clear strobe on entry into reset |
| shift_en_o | output | 1 | Datapath shift enable |
| hold_o | output | 1 | Datapath hold |

## Verification
The embedded properties assume the strobes and the request code are never unknown after reset. They also assume that a soft reset and a state write in the same cycle are legal, and that the soft reset takes priority. The bench changes every input only on the falling clock edge and holds each strobe for exactly one cycle. It reads results at the falling edge, which counts each register between a write and the output it affects. The bench deliberately issues refused writes while the flag is low, and also a soft reset during a settle period, so that the priority and refusal paths are exercised within these assumptions.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    CODE_RESET = 2'd0,
    CODE_RUN   = 2'd1,
    CODE_CLEAR = 2'd2,
    CODE_PAUSE = 2'd3
  } run_code_e;
endpackage

// File: rtl/erc_xition.sv
// Transition decode: accepted write plus current state -> next state.
module erc_xition
  import erc_pkg::*;
(
  input  run_code_e  cur_i,
  input  logic       armed_i,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  output run_code_e  nxt_o,
  output logic       arm_nxt_o,
  output logic       go_o
);
  always_comb begin
    nxt_o     = cur_i;
    arm_nxt_o = armed_i;
    go_o      = 1'b0;
    if (wr_i) begin
      if (cur_i == CODE_PAUSE) begin
        if (armed_i) begin
          arm_nxt_o = 1'b0;
          if (code_i == CODE_CLEAR) begin
            nxt_o = CODE_RESET;
            go_o  = 1'b1;
          end
        end else begin
          case (code_i)
            CODE_CLEAR: arm_nxt_o = 1'b1;
            CODE_RUN: begin
              nxt_o = CODE_RUN;
              go_o  = 1'b1;
            end
            CODE_PAUSE: go_o = 1'b1;
            default: ;
          endcase
        end
      end else if (code_i != CODE_CLEAR) begin
        nxt_o = run_code_e'(code_i);
        go_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/erc_settle.sv
// Settle timer: flag low for SETTLE_CYCLES cycles after each start.
module erc_settle #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic valid_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (start_i) begin
      cnt_d = LOAD;
      vld_d = 1'b0;
    end else if (!vld_q) begin
      if (cnt_q == '0) vld_d = 1'b1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign valid_o = vld_q;

  // R3
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !valid_o);
  // R3
  settle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && cnt_q == '0 && !start_i) |=> valid_o);
endmodule

// File: rtl/engine_run_ctrl.sv
module engine_run_ctrl
  import erc_pkg::*;
#(
  parameter int DW            = 32,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_wr_i,
  input  logic [1:0]    st_code_i,
  input  logic          srst_wr_i,
  input  logic          srst_bit_i,
  output logic [DW-1:0] st_rdata_o,
  output logic          ign_sticky_o,
  output logic          clr_o,
  output logic          shift_en_o,
  output logic          hold_o
);
  localparam int PADW = DW - 3;

  run_code_e state_q, state_d, xnxt;
  logic      armed_q, armed_d, arm_nxt;
  logic      ign_q, ign_d;
  logic      clr_q, clr_d;
  logic      valid, go, srst, acc_wr, ign_set;

  assign srst    = srst_wr_i & srst_bit_i;
  assign acc_wr  = st_wr_i & valid & ~srst;
  assign ign_set = st_wr_i & ~valid & ~srst;

  erc_xition u_xition (
    .cur_i     (state_q),
    .armed_i   (armed_q),
    .wr_i      (acc_wr),
    .code_i    (st_code_i),
    .nxt_o     (xnxt),
    .arm_nxt_o (arm_nxt),
    .go_o      (go)
  );

  erc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (go | srst),
    .valid_o (valid)
  );

  always_comb begin
    state_d = srst ? CODE_RESET : xnxt;
    armed_d = srst ? 1'b0 : arm_nxt;
    ign_d   = srst ? 1'b0 : (ign_q | ign_set);
    clr_d   = srst | (go & (xnxt == CODE_RESET));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CODE_RESET;
      armed_q <= 1'b0;
      ign_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      ign_q   <= ign_d;
      clr_q   <= clr_d;
    end
  end

  assign st_rdata_o   = {{PADW{1'b0}}, valid, state_q};
  assign ign_sticky_o = ign_q;
  assign clr_o        = clr_q;
  assign shift_en_o   = (state_q == CODE_RUN) & valid;
  assign hold_o       = (state_q == CODE_PAUSE);

  // R4
  ignore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && !valid && !srst) |=> $stable(state_q));
  // R4
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && !valid && !srst) |=> ign_sticky_o);
  // R5
  pause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CODE_PAUSE && !armed_q && acc_wr && st_code_i == CODE_CLEAR)
      |=> (state_q == CODE_PAUSE && valid));
  // R9
  srst_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (state_q == CODE_RESET && !valid && !ign_sticky_o && clr_o));
  // R10
  ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_o, shift_en_o, hold_o}));
endmodule

// File: tb/engine_run_ctrl_tb.sv
module engine_run_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam int SETTLE     = 4;
  localparam int NVEC       = 16;

  // {code, expected state after settling}
  localparam logic [3:0] VEC [NVEC] = '{
    {2'd1, 2'd1},  // R2 reset->run
    {2'd3, 2'd3},  // R2 run->pause
    {2'd0, 2'd3},  // R7 direct 0 ignored in pause
    {2'd1, 2'd1},  // R7 pause->run
    {2'd2, 2'd1},  // R8 clear ignored in run
    {2'd3, 2'd3},  // R2
    {2'd2, 2'd3},  // R5 first clear arms
    {2'd1, 2'd3},  // R6 non-clear disarms, stays pause
    {2'd2, 2'd3},  // R6 arm again
    {2'd2, 2'd0},  // R5 second clear -> reset
    {2'd2, 2'd0},  // R8 clear ignored in reset
    {2'd3, 2'd3},  // R2 reset->pause
    {2'd2, 2'd3},  // R5 arm
    {2'd3, 2'd3},  // R6 pause write disarms
    {2'd2, 2'd3},  // R6 arm
    {2'd2, 2'd0}   // R5 exit
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_wr, srst_wr, srst_bit;
  logic [1:0]    st_code;
  logic [DW-1:0] rdata;
  logic          ign, clr, shen, hold;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  engine_run_ctrl #(.DW(DW), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_wr_i      (st_wr),
    .st_code_i    (st_code),
    .srst_wr_i    (srst_wr),
    .srst_bit_i   (srst_bit),
    .st_rdata_o   (rdata),
    .ign_sticky_o (ign),
    .clr_o        (clr),
    .shift_en_o   (shen),
    .hold_o       (hold)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rb(input logic v, input logic [1:0] s);
    return {{(DW-3){1'b0}}, v, s};
  endfunction

  task automatic wr_state(input logic [1:0] c);
    st_wr = 1'b1; st_code = c;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic wr_srst(input logic b);
    srst_wr = 1'b1; srst_bit = b;
    @(negedge clk);
    srst_wr = 1'b0; srst_bit = 1'b0;
  endtask

  task automatic settle_wait();
    repeat (SETTLE + 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_wr = 1'b0; st_code = 2'd0; srst_wr = 1'b0; srst_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 readback", rdata, rb(1'b1, 2'd0));
    check("R1 outputs", {28'd0, ign, clr, shen, hold}, 32'd0);

    // table walk: R2 R5 R6 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      wr_state(VEC[i][3:2]);
      settle_wait();
      check($sformatf("R2 R11 vector %0d", i), rdata, rb(1'b1, VEC[i][1:0]));
    end

    // R3 settle window and R10 shift enable gating (state reset now)
    wr_state(2'd1);
    check("R3 flag low at +0", {31'd0, rdata[2]}, 32'd0);
    check("R10 shift gated", {31'd0, shen}, 32'd0);
    for (int k = 1; k < SETTLE; k++) begin
      @(negedge clk);
      check("R3 flag still low", {31'd0, rdata[2]}, 32'd0);
    end
    @(negedge clk);
    check("R3 flag back high", rdata, rb(1'b1, 2'd1));
    check("R10 shift on in run", {31'd0, shen}, 32'd1);

    // R4 refused write during settle
    wr_state(2'd3);
    wr_state(2'd0);
    check("R4 sticky set", {31'd0, ign}, 32'd1);
    settle_wait();
    check("R4 state kept", rdata, rb(1'b1, 2'd3));
    check("R10 hold in pause", {30'd0, shen, hold}, 32'd1);

    // R5 back-to-back clears in consecutive cycles
    st_wr = 1'b1; st_code = 2'd2;
    @(negedge clk);
    @(negedge clk);
    st_wr = 1'b0;
    check("R5 reset after two clears", rdata, rb(1'b0, 2'd0));
    check("R10 clr strobe", {31'd0, clr}, 32'd1);
    check("R4 sticky held", {31'd0, ign}, 32'd1);
    @(negedge clk);
    check("R10 clr one cycle", {31'd0, clr}, 32'd0);
    settle_wait();

    // R9 soft reset during settle clears sticky
    wr_state(2'd1);
    wr_srst(1'b1);
    check("R9 forced reset", rdata, rb(1'b0, 2'd0));
    check("R9 sticky cleared", {31'd0, ign}, 32'd0);
    check("R9 clr strobe", {31'd0, clr}, 32'd1);
    settle_wait();
    check("R9 settled", rdata, rb(1'b1, 2'd0));

    // R9 soft reset drops a pending clear
    wr_state(2'd3);
    settle_wait();
    wr_state(2'd2);
    wr_srst(1'b1);
    settle_wait();
    wr_state(2'd3);
    settle_wait();
    wr_state(2'd2);
    settle_wait();
    check("R9 arm dropped", rdata, rb(1'b1, 2'd3));

    // R9 soft reset with bit 0 clear: no effect
    wr_srst(1'b0);
    settle_wait();
    check("R9 zero write ignored", rdata, rb(1'b1, 2'd3));

    // R9 soft reset wins over same-cycle state write
    srst_wr = 1'b1; srst_bit = 1'b1; st_wr = 1'b1; st_code = 2'd1;
    @(negedge clk);
    srst_wr = 1'b0; srst_bit = 1'b0; st_wr = 1'b0;
    settle_wait();
    check("R9 priority", rdata, rb(1'b1, 2'd0));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule